// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the command side of an SDRAM device model or controller shadow. On every rising clock edge it samples chip select, the three command strobes, the bank bits and the address bus. It turns them into one decoded command code. It also keeps a live picture of the four banks: which bank has a row open, and the row address held by each open bank. Mode-register loads are steered to either the base or the extended register, depending on the bank bits.

A command that breaks the bank rules raises a one-cycle illegal flag and changes nothing. The rule is broken by opening a bank that is already open, or by reading or writing a bank that is closed. When clock enable is sampled low, the block moves to one of three low-power states. Which one depends on the command seen at that edge and on whether any row is open. It stays in that state until clock enable is sampled high again.

All outputs are registered. They show the effect of the inputs sampled at a rising edge right after that edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset, every bank is closed and every stored row is 0. The command output is NONE, the illegal flag is low, the power state is RUN (0), and both mode registers read 0.
- R2: At an edge where chip select is high and clock enable is high, the command output becomes NONE (0). The illegal flag stays low and no bank, row or mode register changes.
- R3: With chip select low and clock enable high, {ras,cas,we} is decoded as follows. 111 gives NOP (1), 011 ACTIVE (2), 101 READ (3) and 100 WRITE (4). 010 gives PRECHARGE (5), 001 AUTO REFRESH (6), 000 MODE REGISTER SET (7) and 110 BURST STOP (8). The code is presented after the same edge.
- R4: A legal ACTIVE opens the bank given by the 2-bit bank input and stores the 12-bit address as that bank's row. The row appears in openRows at bits [b*12 +: 12].
- R5: PRECHARGE with address bit 10 low closes only the addressed bank. With bit 10 high it closes all four banks. A bank that is already closed may be precharged without error.
- R6: A READ or WRITE with address bit 10 high closes its bank AP_CYCLES edges after the command edge (default 4). Without bit 10 the bank stays open. A precharge cancels a pending close.
- R7: The illegal flag goes high for one cycle after an ACTIVE to an open bank, or a READ or WRITE to a closed bank. Such a command leaves banks and rows unchanged.
- R8: MODE REGISTER SET with bank bits 00 loads the 12-bit address into the base register. With bank bits 10 it loads the extended register. Bank bits 01 or 11 raise the illegal flag and load neither register.
- R9: While in RUN, an edge with clock enable low changes the power state. AUTO REFRESH with all banks closed gives self refresh (3). Any other command with a bank open gives active power-down (2); with all banks closed it gives precharge power-down (1). While clock enable is low, commands are ignored and the command output is NONE. The first edge with clock enable high returns to RUN and decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row address, column address with bit 10 as auto precharge, or mode opcode |
| cmdOut | output | 4 | Decoded command code of the last edge |
| illegal | output | 1 | Last command broke a bank rule |
| bankOpen | output | 4 | One bit per bank, high when a row is open |
| openRows | output | 48 | Row address of each bank, 12 bits per bank |
| pwrState | output | 2 | 0 run, 1 precharge power-down, 2 active power-down, 3 self refresh |
| modeBase | output | 12 | Base mode register |
| modeExt | output | 12 | Extended mode register |

## Verification
A bank bit that is wrong inside the block is visible on bankOpen right after the edge that caused it. It also shows up one edge later on the illegal flag, when the next ACTIVE, READ or WRITE to that bank is judged against the wrong state. An auto-precharge counter that is off by one moves the closing edge, so each such access is followed edge by edge until its bank drops. The power state is checked at entry and exit for each of the three low-power kinds, and with a blocked command inside the low-power window.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_NONE = 4'd0,
    CMD_NOP  = 4'd1,
    CMD_ACT  = 4'd2,
    CMD_RD   = 4'd3,
    CMD_WR   = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_REF  = 4'd6,
    CMD_MRS  = 4'd7,
    CMD_BST  = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_PPD  = 2'd1,
    PWR_APD  = 2'd2,
    PWR_SELF = 2'd3
  } pwr_e;

  // strobes from the control to the bank datapath
  typedef struct packed {
    logic act;
    logic rdwr;
    logic autoPre;
    logic preOne;
    logic preAll;
    logic mrsBase;
    logic mrsExt;
  } bank_stb_t;

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int MR_BASE_SEL = 0,
  parameter int MR_EXT_SEL  = 2,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BA_W-1:0]      ba,
  input  logic                 apFlag,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output bank_stb_t            stb,
  output cmd_e                 cmdOut,
  output logic                 illegal,
  output pwr_e                 pwrState
);

  cmd_e cmdRaw;
  logic targetOpen;
  logic selOk;
  logic badCmd;
  logic anyOpen;
  pwr_e pwrNext;
  cmd_e cmdQ;
  logic illQ;
  pwr_e pwrQ;

  always_comb begin
    cmdRaw = CMD_NONE;
    if (!csN) begin
      unique case ({rasN, casN, weN})
        3'b111: cmdRaw = CMD_NOP;
        3'b011: cmdRaw = CMD_ACT;
        3'b101: cmdRaw = CMD_RD;
        3'b100: cmdRaw = CMD_WR;
        3'b010: cmdRaw = CMD_PRE;
        3'b001: cmdRaw = CMD_REF;
        3'b000: cmdRaw = CMD_MRS;
        default: cmdRaw = CMD_BST;
      endcase
    end
  end

  always_comb begin
    targetOpen = bankOpen[ba];
    selOk      = (ba == BA_W'(MR_BASE_SEL)) || (ba == BA_W'(MR_EXT_SEL));
    badCmd     = cke && (((cmdRaw == CMD_ACT) && targetOpen) ||
                         (((cmdRaw == CMD_RD) || (cmdRaw == CMD_WR)) && !targetOpen) ||
                         ((cmdRaw == CMD_MRS) && !selOk));
    stb = '0;
    if (cke && !badCmd) begin
      stb.act     = (cmdRaw == CMD_ACT);
      stb.rdwr    = (cmdRaw == CMD_RD) || (cmdRaw == CMD_WR);
      stb.autoPre = apFlag;
      stb.preOne  = (cmdRaw == CMD_PRE) && !apFlag;
      stb.preAll  = (cmdRaw == CMD_PRE) && apFlag;
      stb.mrsBase = (cmdRaw == CMD_MRS) && (ba == BA_W'(MR_BASE_SEL));
      stb.mrsExt  = (cmdRaw == CMD_MRS) && (ba == BA_W'(MR_EXT_SEL));
    end
  end

  always_comb begin
    anyOpen = |bankOpen;
    pwrNext = pwrQ;
    if (cke) begin
      pwrNext = PWR_RUN;
    end else if (pwrQ == PWR_RUN) begin
      if ((cmdRaw == CMD_REF) && !anyOpen) pwrNext = PWR_SELF;
      else if (anyOpen)                    pwrNext = PWR_APD;
      else                                 pwrNext = PWR_PPD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ <= CMD_NONE;
      illQ <= 1'b0;
      pwrQ <= PWR_RUN;
    end else begin
      cmdQ <= cke ? cmdRaw : CMD_NONE;
      illQ <= badCmd;
      pwrQ <= pwrNext;
    end
  end

  assign cmdOut   = cmdQ;
  assign illegal  = illQ;
  assign pwrState = pwrQ;

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cke && csN) |=> (cmdOut == CMD_NONE && !illegal)); // R2

  AST_ACT_OPEN_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (cke && !csN && !rasN && casN && weN && bankOpen[ba]) |=> illegal); // R7

  AST_SLEEP_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> (cmdOut == CMD_NONE && !illegal)); // R9

  AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> (pwrState == PWR_RUN)); // R9

endmodule

// File: rtl/sdram_bank_dp.sv
module sdram_bank_dp
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int AP_CYCLES = 4,
  localparam int BA_W = $clog2(NUM_BANKS),
  localparam int CNT_W = $clog2(AP_CYCLES + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bank_stb_t                  stb,
  input  logic [BA_W-1:0]            bank,
  input  logic [ROW_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic [ROW_W-1:0]           modeBase,
  output logic [ROW_W-1:0]           modeExt
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             openQ;
    logic [ROW_W-1:0] rowQ;
    logic [CNT_W-1:0] apCnt;
    logic             hit;

    assign hit = (bank == BA_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ <= 1'b0;
        rowQ  <= '0;
        apCnt <= '0;
      end else if (stb.preAll || (stb.preOne && hit)) begin
        openQ <= 1'b0;
        apCnt <= '0;
      end else if (stb.act && hit) begin
        openQ <= 1'b1;
        rowQ  <= addr;
      end else if (stb.rdwr && hit && stb.autoPre) begin
        apCnt <= CNT_W'(AP_CYCLES);
      end else if (apCnt != '0) begin
        apCnt <= apCnt - 1'b1;
        if (apCnt == CNT_W'(1)) openQ <= 1'b0;
      end
    end

    assign bankOpen[b] = openQ;
    assign openRows[b*ROW_W +: ROW_W] = rowQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBase <= '0;
      modeExt  <= '0;
    end else begin
      if (stb.mrsBase) modeBase <= addr;
      if (stb.mrsExt)  modeExt  <= addr;
    end
  end

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    stb.act |=> (bankOpen[$past(bank)] &&
                 openRows[$past(bank)*ROW_W +: ROW_W] == $past(addr))); // R4

  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    stb.preAll |=> (bankOpen == '0)); // R5

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.mrsBase |=> $stable(modeBase)); // R8

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 12,
  parameter int AP_BIT      = 10,
  parameter int AP_CYCLES   = 4,
  parameter int MR_BASE_SEL = 0,
  parameter int MR_EXT_SEL  = 2,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cke,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [3:0]                 cmdOut,
  output logic                       illegal,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic [1:0]                 pwrState,
  output logic [ROW_W-1:0]           modeBase,
  output logic [ROW_W-1:0]           modeExt
);

  bank_stb_t stb;
  cmd_e      cmdQ;
  pwr_e      pwrQ;

  sdram_cmd_ctrl #(
    .NUM_BANKS  (NUM_BANKS),
    .MR_BASE_SEL(MR_BASE_SEL),
    .MR_EXT_SEL (MR_EXT_SEL)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cke     (cke),
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .ba      (ba),
    .apFlag  (addr[AP_BIT]),
    .bankOpen(bankOpen),
    .stb     (stb),
    .cmdOut  (cmdQ),
    .illegal (illegal),
    .pwrState(pwrQ)
  );

  sdram_bank_dp #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W),
    .AP_CYCLES(AP_CYCLES)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .bank    (ba),
    .addr    (addr),
    .bankOpen(bankOpen),
    .openRows(openRows),
    .modeBase(modeBase),
    .modeExt (modeExt)
  );

  assign cmdOut   = cmdQ;
  assign pwrState = pwrQ;

endmodule

// File: tb/test_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module test_sdram_cmd_tracker;

  localparam int AP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  cmdOut;
  logic        illegal;
  logic [3:0]  bankOpen;
  logic [47:0] openRows;
  logic [1:0]  pwrState;
  logic [11:0] modeBase, modeExt;

  always #2 clk = ~clk;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .cmdOut(cmdOut), .illegal(illegal),
    .bankOpen(bankOpen), .openRows(openRows), .pwrState(pwrState),
    .modeBase(modeBase), .modeExt(modeExt)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic        ill;
    logic [3:0]  open;
    logic [47:0] rows;
    logic [1:0]  pwr;
    logic [11:0] mb;
    logic [11:0] me;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int fails = 0;

  // bench model state
  logic        mOpen[4];
  logic [11:0] mRow[4];
  int          mCnt[4];
  logic [1:0]  mPwr = 0;
  logic [11:0] mBase = 0, mExt = 0;

  initial for (int i = 0; i < 4; i++) begin mOpen[i] = 0; mRow[i] = 0; mCnt[i] = 0; end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // driver: applies one command per edge and pushes the expected result
  task automatic step(input logic k, input logic [3:0] code, input logic [1:0] b,
                      input logic [11:0] a, input string tag);
    logic [3:0] c;
    logic any, ill, dAct, dRdwr, dPreOne, dPreAll;
    exp_t e;
    @(negedge clk);
    cke = k; {csN, rasN, casN, weN} = code; ba = b; addr = a;
    any = mOpen[0] | mOpen[1] | mOpen[2] | mOpen[3];
    c = 0;
    if (!code[3]) begin
      case (code[2:0])
        3'b111: c = 1; 3'b011: c = 2; 3'b101: c = 3; 3'b100: c = 4;
        3'b010: c = 5; 3'b001: c = 6; 3'b000: c = 7; default: c = 8;
      endcase
    end
    ill = k && ((c == 2 && mOpen[b]) || ((c == 3 || c == 4) && !mOpen[b]) ||
                (c == 7 && !(b == 0 || b == 2)));
    dAct = k && !ill && c == 2;
    dRdwr = k && !ill && (c == 3 || c == 4);
    dPreOne = k && c == 5 && !a[10];
    dPreAll = k && c == 5 && a[10];
    if (k && !ill && c == 7 && b == 0) mBase = a;
    if (k && !ill && c == 7 && b == 2) mExt = a;
    if (k) mPwr = 0;
    else if (mPwr == 0) mPwr = (c == 6 && !any) ? 2'd3 : (any ? 2'd2 : 2'd1);
    for (int i = 0; i < 4; i++) begin
      if (dPreAll || (dPreOne && b == i)) begin mOpen[i] = 0; mCnt[i] = 0; end
      else if (dAct && b == i) begin mOpen[i] = 1; mRow[i] = a; end
      else if (dRdwr && b == i && a[10]) mCnt[i] = AP;
      else if (mCnt[i] != 0) begin mCnt[i]--; if (mCnt[i] == 0) mOpen[i] = 0; end
    end
    e.cmd = k ? c : 4'd0;
    e.ill = ill;
    e.open = {mOpen[3], mOpen[2], mOpen[1], mOpen[0]};
    e.rows = {mRow[3], mRow[2], mRow[1], mRow[0]};
    e.pwr = mPwr; e.mb = mBase; e.me = mExt; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: pops one expected item per edge and compares the ports
  initial begin
    forever begin
      @(posedge clk); #1;
      if (expQ.size() != 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (cmdOut !== e.cmd || illegal !== e.ill || bankOpen !== e.open ||
            openRows !== e.rows || pwrState !== e.pwr || modeBase !== e.mb ||
            modeExt !== e.me) begin
          fails++;
          $display("FAIL %s: actual cmd=%0d ill=%0b open=%b rows=%h pwr=%0d mb=%h me=%h expected cmd=%0d ill=%0b open=%b rows=%h pwr=%0d mb=%h me=%h",
                   e.tag, cmdOut, illegal, bankOpen, openRows, pwrState, modeBase, modeExt,
                   e.cmd, e.ill, e.open, e.rows, e.pwr, e.mb, e.me);
        end
      end
    end
  end

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  localparam logic [3:0] DES = 4'b1011, NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101,
                         WR = 4'b0100, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000,
                         BST = 4'b0110;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (cmdOut !== 0 || illegal !== 0 || bankOpen !== 0 || openRows !== 0 ||
        pwrState !== 0 || modeBase !== 0 || modeExt !== 0) begin
      fails++;
      $display("FAIL R1 reset: actual cmd=%0d ill=%0b open=%b pwr=%0d expected all zero",
               cmdOut, illegal, bankOpen, pwrState);
    end
    rstN = 1'b1;
    step(1, DES,  0, 12'h123, "R2 deselect with active bits");
    step(1, NOP,  0, 0,       "R3 nop");
    step(1, ACT,  0, 12'h123, "R4 open bank0");
    step(1, ACT,  2, 12'hABC, "R4 open bank2");
    step(1, ACT,  0, 12'h555, "R7 active to open bank");
    step(1, RD,   1, 12'h010, "R7 read to closed bank");
    step(1, WR,   3, 12'h010, "R7 write to closed bank");
    step(1, RD,   0, 12'h004, "R3 read without auto precharge");
    step(1, BST,  0, 0,       "R3 burst stop");
    step(1, WR,   2, 12'h408, "R6 write with auto precharge");
    for (int i = 0; i < AP + 1; i++) step(1, NOP, 0, 0, "R6 auto precharge countdown");
    step(1, RD,   0, 12'h400, "R6 read with auto precharge");
    step(1, NOP,  0, 0,       "R6 pending");
    step(1, PRE,  0, 12'h000, "R6 precharge cancels pending");
    for (int i = 0; i < AP; i++) step(1, NOP, 0, 0, "R6 stays closed after cancel");
    step(1, ACT,  1, 12'h0F1, "R4 open bank1");
    step(1, ACT,  3, 12'hF03, "R4 open bank3");
    step(1, ACT,  0, 12'h7E0, "R4 reopen bank0");
    step(1, PRE,  1, 12'h000, "R5 precharge one bank");
    step(1, PRE,  2, 12'h000, "R5 precharge closed bank");
    step(1, PRE,  2, 12'h400, "R5 precharge all");
    step(1, MRS,  0, 12'h033, "R8 base mode load");
    step(1, MRS,  2, 12'h005, "R8 extended mode load");
    step(1, MRS,  1, 12'hFFF, "R8 bad select");
    step(1, MRS,  3, 12'hEEE, "R8 bad select");
    step(1, REF,  0, 0,       "R3 auto refresh");
    step(1, ACT,  1, 12'h222, "R4 open bank1 before sleep");
    step(0, NOP,  0, 0,       "R9 active power-down entry");
    step(0, ACT,  2, 12'h111, "R9 ignored while asleep");
    step(0, PRE,  1, 12'h400, "R9 ignored while asleep");
    step(1, NOP,  0, 0,       "R9 wake");
    step(1, PRE,  0, 12'h400, "R5 close all before sleep");
    step(0, NOP,  0, 0,       "R9 precharge power-down entry");
    step(0, REF,  0, 0,       "R9 refresh does not switch kind");
    step(1, NOP,  0, 0,       "R9 wake");
    step(0, REF,  0, 0,       "R9 self refresh entry");
    step(0, DES,  0, 0,       "R9 self refresh hold");
    step(1, ACT,  3, 12'h3C3, "R9 wake decodes command");
    step(1, NOP,  0, 0,       "R3 final nop");
    @(negedge clk); @(negedge clk);
    summary();
    $finish;
  end

endmodule